// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides whether a received Ethernet frame is kept, judging only by its six-byte destination address. The receive path pulses a frame-start strobe, then presents the destination bytes one per clock in wire order. One clock after the sixth byte has been taken, the block raises a decision-valid flag together with exactly one of accept or reject. It holds that result until the next frame-start.

The verdict has four rules. A promiscuous setting keeps everything. The all-ones address is kept only when broadcast reception is enabled. Group addresses are kept when multicast reception is enabled and one bit of a 64-bit hash table, chosen by a CRC-based hash, is set. Individual addresses are kept only on an exact match with the programmed station address. The hash index is exported so that upstream logic and tests can see which table bit was consulted.

The receive configuration, the station address and the hash table are loaded through a small synchronous write port.

Top module: `addr_filter`

## Requirements
- R1: When receive-configuration bit 4 (value 0x10) is set, every frame is accepted, whatever its destination.
- R2: A destination of all ones (FF:FF:FF:FF:FF:FF) is broadcast. Without promiscuous mode, it is accepted exactly when receive-configuration bit 2 (value 0x04) is set.
- R3: Any other destination whose first byte has bit 0 set is a group address. Without promiscuous mode, it is accepted only when receive-configuration bit 3 (value 0x08) is set and the hash-table bit chosen by the hash index is set. Table byte k sits at write address 0x08+k. Index bits [5:3] choose the table byte and bits [2:0] choose the bit within that byte.
- R4: The hash index is the top six bits of a 32-bit CRC. The CRC starts at all ones and is run over the six destination bytes in order, each byte least significant bit first. For each bit, the feedback is the CRC MSB XOR the data bit, and the CRC shifts left by one. When the feedback is 1, the CRC is XORed with 0x04C11DB6 and bit 0 is forced to 1. The index is valid on hash_idx while decision_vld is high.
- R5: Any remaining (individual) destination is accepted, when not in promiscuous mode, only if all six bytes equal the station address. Station byte k (k=0 is the first byte on the wire) sits at write address 0x01+k. The receive configuration sits at address 0x00.
- R6: decision_vld is low in the cycle just after the sixth byte is consumed and high in the cycle after that. While decision_vld is high, exactly one of accept and reject is high; while it is low, both are low.
- R7: Once valid, the decision and hash_idx are held unchanged until the next frame-start. Bytes offered after the sixth are ignored.
- R8: After reset, decision_vld, accept and reject are low, and all configuration, station and table registers are zero, so a broadcast frame is rejected.
- R9: A frame-start pulse clears the decision on the next clock and restarts the address capture. A byte offered in the same cycle as frame-start is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_start | input | 1 | One-cycle pulse that starts a new frame |
| byte_vld | input | 1 | byte_data carries a destination byte this cycle |
| byte_data | input | 8 | Destination byte, wire order |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 5 | Register write address |
| cfg_wr_data | input | 8 | Register write data |
| decision_vld | output | 1 | Verdict is valid |
| accept | output | 1 | Frame is to be kept |
| reject | output | 1 | Frame is to be dropped |
| hash_idx | output | 6 | Hash index of the destination |

## Verification
A CRC register that is off by even one bit shows up at hash_idx in the cycle the verdict appears. The bench compares that value against a software CRC for every group address it sends, including the all-hosts group. A wrong byte counter or a wrong match flag shows up as a verdict that is early, late, or inverted. The bench samples decision_vld both one and two cycles after the last byte and checks accept against a reference filter for each of the four address classes. Stale state left from an earlier frame is exposed by back-to-back frames of different classes, and by checking that decision_vld drops on the clock after frame-start.

// File: rtl/addr_filt_pkg.sv
// Package: shared constants for the destination address filter.
// Assumes byte-wide destination input in wire order and a 5-bit register space.
package addr_filt_pkg;
    localparam int          MAC_BYTES   = 6;
    localparam int          BYTE_W      = 8;
    localparam int          HASH_W      = 6;
    localparam int          TBL_BYTES   = 8;
    localparam int          CRC_W       = 32;
    localparam logic [31:0] CRC_POLY    = 32'h04C1_1DB6;
    localparam logic [31:0] CRC_SEED    = 32'hFFFF_FFFF;
    localparam int          CFG_BCAST   = 2;
    localparam int          CFG_MCAST   = 3;
    localparam int          CFG_PROMISC = 4;
    localparam int          REG_AW      = 5;
    localparam logic [4:0]  REG_CFG     = 5'h00;
    localparam logic [4:0]  REG_STA     = 5'h01;
    localparam logic [4:0]  REG_TBL     = 5'h08;

    typedef enum logic [1:0] {
        DST_INDIV = 2'd0,
        DST_GROUP = 2'd1,
        DST_BCAST = 2'd2
    } dst_kind_e;
endpackage

// File: rtl/af_cfg_regs.sv
// Module: af_cfg_regs
// Holds the receive configuration, the station address and the hash table.
// Assumes single-cycle writes; the registers are not readable; synchronous active-low reset.
module af_cfg_regs
    import addr_filt_pkg::*;
#(
    parameter int N_STA = MAC_BYTES,
    parameter int N_TBL = TBL_BYTES,
    parameter int AW    = REG_AW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [7:0]           wr_data,
    output logic [7:0]           rx_cfg,
    output logic [N_STA*8-1:0]   station,
    output logic [N_TBL*8-1:0]   hash_tbl
);
    // Receive-configuration register update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_cfg <= '0;
        else if (wr_en && wr_addr == AW'(REG_CFG))
            rx_cfg <= wr_data;
    end

    genvar g;
    generate
        for (g = 0; g < N_STA; g++) begin : g_sta
            // Station byte g update.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    station[g*8 +: 8] <= '0;
                else if (wr_en && wr_addr == AW'(int'(REG_STA) + g))
                    station[g*8 +: 8] <= wr_data;
            end
        end
        for (g = 0; g < N_TBL; g++) begin : g_tbl
            // Hash-table byte g update.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    hash_tbl[g*8 +: 8] <= '0;
                else if (wr_en && wr_addr == AW'(int'(REG_TBL) + g))
                    hash_tbl[g*8 +: 8] <= wr_data;
            end
        end
    endgenerate
endmodule

// File: rtl/af_crc_hash.sv
// Module: af_crc_hash
// Runs the hash CRC over one byte per clock, least significant bit first.
// Exports the top bits of the CRC as the hash index.
// Assumes clr has priority over step.
module af_crc_hash
    import addr_filt_pkg::*;
#(
    parameter int              CW    = CRC_W,
    parameter logic [CW-1:0]   POLY  = CRC_POLY,
    parameter logic [CW-1:0]   SEED  = CRC_SEED,
    parameter int              DW    = BYTE_W,
    parameter int              IW    = HASH_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    input  logic [DW-1:0] din,
    output logic [IW-1:0] idx
);
    logic [CW-1:0] crc_q;

    function automatic logic [CW-1:0] crc_byte(input logic [CW-1:0] c, input logic [DW-1:0] d);
        logic [CW-1:0] r;
        logic          fb;
        r = c;
        for (int j = 0; j < DW; j++) begin
            fb = r[CW-1] ^ d[j];
            r  = r << 1;
            if (fb)
                r = (r ^ POLY) | CW'(1);
        end
        return r;
    endfunction

    // CRC register: seed on reset or clear, advance one byte per step.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            crc_q <= SEED;
        else if (step)
            crc_q <= crc_byte(crc_q, din);
    end

    assign idx = crc_q[CW-1 -: IW];
endmodule

// File: rtl/af_addr_track.sv
// Module: af_addr_track
// Counts the destination bytes and builds the per-frame address flags:
// all-ones, group bit, and station match.
// Assumes station byte 0 is the first byte on the wire; bytes after the last are dropped.
module af_addr_track
    import addr_filt_pkg::*;
#(
    parameter int N  = MAC_BYTES,
    parameter int DW = BYTE_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            byte_vld,
    input  logic [DW-1:0]   din,
    input  logic [N*DW-1:0] station,
    output logic            take,
    output logic            full,
    output logic            all_ones,
    output logic            grp_bit,
    output logic            sta_hit
);
    localparam int CNT_W = $clog2(N + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [DW-1:0]    sta_byte;

    // Byte acceptance and the station byte the current byte is compared with.
    always_comb begin
        full     = (cnt_q == CNT_W'(N));
        take     = byte_vld && !clr && !full;
        sta_byte = station[cnt_q*DW +: DW];
    end

    // Byte counter and address flags.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q    <= '0;
            all_ones <= 1'b1;
            sta_hit  <= 1'b1;
            grp_bit  <= 1'b0;
        end else if (take) begin
            cnt_q    <= cnt_q + 1'b1;
            all_ones <= all_ones && (din == '1);
            sta_hit  <= sta_hit && (din == sta_byte);
            if (cnt_q == '0)
                grp_bit <= din[0];
        end
    end
endmodule

// File: rtl/addr_filter.sv
// Module: addr_filter (top)
// Classifies each destination address as broadcast, group or individual.
// Applies the enable bits, the hash table and the station compare, and registers
// the verdict one clock after the last byte.
// Assumes frm_start precedes the bytes of each frame.
module addr_filter
    import addr_filt_pkg::*;
#(
    parameter int N_ADDR = MAC_BYTES,
    parameter int N_TBL  = TBL_BYTES,
    parameter int AW     = REG_AW,
    parameter int IW     = HASH_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frm_start,
    input  logic          byte_vld,
    input  logic [7:0]    byte_data,
    input  logic          cfg_wr_en,
    input  logic [AW-1:0] cfg_wr_addr,
    input  logic [7:0]    cfg_wr_data,
    output logic          decision_vld,
    output logic          accept,
    output logic          reject,
    output logic [IW-1:0] hash_idx
);
    logic [7:0]          rx_cfg;
    logic [N_ADDR*8-1:0] station;
    logic [N_TBL*8-1:0]  hash_tbl;
    logic                take, addr_full, all_ones, grp_bit, sta_hit;
    dst_kind_e           kind;
    logic                verdict;

    af_cfg_regs #(.N_STA(N_ADDR), .N_TBL(N_TBL), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr),
        .wr_data(cfg_wr_data), .rx_cfg(rx_cfg), .station(station), .hash_tbl(hash_tbl)
    );

    af_addr_track #(.N(N_ADDR), .DW(8)) u_track (
        .clk(clk), .rst_n(rst_n), .clr(frm_start), .byte_vld(byte_vld),
        .din(byte_data), .station(station), .take(take), .full(addr_full),
        .all_ones(all_ones), .grp_bit(grp_bit), .sta_hit(sta_hit)
    );

    af_crc_hash #(.IW(IW)) u_crc (
        .clk(clk), .rst_n(rst_n), .clr(frm_start), .step(take),
        .din(byte_data), .idx(hash_idx)
    );

    // Address class and filter verdict from the captured flags.
    always_comb begin
        if (all_ones)
            kind = DST_BCAST;
        else if (grp_bit)
            kind = DST_GROUP;
        else
            kind = DST_INDIV;
        unique case (kind)
            DST_BCAST: verdict = rx_cfg[CFG_BCAST];
            DST_GROUP: verdict = rx_cfg[CFG_MCAST] && hash_tbl[hash_idx];
            default:   verdict = sta_hit;
        endcase
        if (rx_cfg[CFG_PROMISC])
            verdict = 1'b1;
    end

    // Decision register: cleared on frame start, loaded once per frame.
    always_ff @(posedge clk) begin
        if (!rst_n || frm_start) begin
            decision_vld <= 1'b0;
            accept       <= 1'b0;
            reject       <= 1'b0;
        end else if (addr_full && !decision_vld) begin
            decision_vld <= 1'b1;
            accept       <= verdict;
            reject       <= !verdict;
        end
    end
endmodule

// File: rtl/af_checker.sv
// Module: af_checker
// Temporal properties of the filter outputs, bound to addr_filter.
module af_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       frm_start,
    input logic       decision_vld,
    input logic       accept,
    input logic       reject,
    input logic       promisc,
    input logic       addr_full,
    input logic [5:0] hash_idx
);
    // R6
    one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        decision_vld |-> (accept ^ reject));
    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !decision_vld |-> (!accept && !reject));
    // R6
    verdict_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_full && !decision_vld && !frm_start) |=> decision_vld);
    // R7
    verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (decision_vld && !frm_start) |=> (decision_vld && $stable(accept) && $stable(hash_idx)));
    // R9
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_start |=> !decision_vld);
    // R1
    promisc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(decision_vld) && $past(promisc)) |-> accept);
endmodule

bind addr_filter af_checker u_chk (
    .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .decision_vld(decision_vld),
    .accept(accept), .reject(reject), .promisc(rx_cfg[4]), .addr_full(addr_full),
    .hash_idx(hash_idx)
);

// File: tb/addr_filter_bench.sv
module addr_filter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frm_start = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_data = '0;
    logic       cfg_wr_en = 1'b0;
    logic [4:0] cfg_wr_addr = '0;
    logic [7:0] cfg_wr_data = '0;
    logic       decision_vld, accept, reject;
    logic [5:0] hash_idx;

    int total = 0;
    int bad   = 0;

    localparam logic [47:0] STA  = 48'h02_11_22_33_44_55;
    localparam logic [47:0] ALLH = 48'h01_00_5E_00_00_01;

    // {config, destination}
    localparam logic [55:0] VECS [13] = '{
        {8'h10, 48'h0A_0B_0C_0D_0E_0F},
        {8'h04, 48'hFF_FF_FF_FF_FF_FF},
        {8'h08, 48'hFF_FF_FF_FF_FF_FF},
        {8'h08, ALLH},
        {8'h04, ALLH},
        {8'h08, 48'h33_33_FF_00_00_01},
        {8'h00, STA},
        {8'h0C, 48'h02_11_22_33_44_54},
        {8'h00, 48'h03_11_22_33_44_55},
        {8'h10, 48'hFF_FF_FF_FF_FF_FF},
        {8'h04, 48'hFF_FF_FF_FF_FF_FE},
        {8'h08, 48'h01_00_5E_7F_FF_FA},
        {8'h0C, 48'h01_80_C2_00_00_00}
    };

    addr_filter u_addr_filter (
        .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .byte_vld(byte_vld),
        .byte_data(byte_data), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
        .cfg_wr_data(cfg_wr_data), .decision_vld(decision_vld), .accept(accept),
        .reject(reject), .hash_idx(hash_idx)
    );

    always #2 clk = ~clk;

    function automatic logic [5:0] ref_idx(input logic [47:0] d);
        logic [31:0] c;
        logic [7:0]  b;
        logic        fb;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < 6; i++) begin
            b = d[47-8*i -: 8];
            for (int j = 0; j < 8; j++) begin
                fb = c[31] ^ b[j];
                c  = c << 1;
                if (fb) c = (c ^ 32'h04C1_1DB6) | 32'h1;
            end
        end
        return c[31:26];
    endfunction

    function automatic logic ref_acc(input logic [7:0] c, input logic [47:0] d,
                                     input logic [63:0] tbl);
        if (c[4])           return 1'b1;
        else if (d == '1)   return c[2];
        else if (d[40])     return c[3] && tbl[ref_idx(d)];
        else                return d == STA;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
        cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic load_tbl(input logic [63:0] tbl);
        for (int k = 0; k < 8; k++) wr_reg(5'(8 + k), tbl[8*k +: 8]);
    endtask

    // Start a frame, send six bytes, check the early and the due cycle (R6).
    task automatic send_dest(input logic [47:0] d);
        frm_start = 1'b1;
        @(negedge clk);
        frm_start = 1'b0;
        check("R9 cleared after start", 32'(decision_vld), 32'd0);
        for (int i = 0; i < 6; i++) begin
            byte_vld = 1'b1; byte_data = d[47-8*i -: 8];
            @(negedge clk);
        end
        byte_vld = 1'b0;
        check("R6 not valid one cycle after last byte", 32'(decision_vld), 32'd0);
        @(negedge clk);
        check("R6 valid two cycles after last byte", 32'(decision_vld), 32'd1);
        check("R6 one-hot verdict", 32'(accept ^ reject), 32'd1);
    endtask

    initial begin
        #(4 * 150000);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] tbl;
        logic [5:0]  ai;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        check("R8 vld after reset", 32'(decision_vld), 32'd0);
        check("R8 accept after reset", 32'(accept), 32'd0);
        check("R8 reject after reset", 32'(reject), 32'd0);
        send_dest(48'hFF_FF_FF_FF_FF_FF);
        check("R8 broadcast rejected with reset config", 32'(accept), 32'd0);

        for (int k = 0; k < 6; k++) wr_reg(5'(1 + k), STA[47-8*k -: 8]);
        tbl = '0;
        ai  = ref_idx(ALLH);
        tbl[ai] = 1'b1;
        load_tbl(tbl);

        // Vector walk: R1, R2, R3, R4, R5
        for (int v = 0; v < 13; v++) begin
            wr_reg(5'h00, VECS[v][55:48]);
            send_dest(VECS[v][47:0]);
            check("R1/R2/R3/R5 verdict", 32'(accept),
                  32'(ref_acc(VECS[v][55:48], VECS[v][47:0], tbl)));
            check("R4 hash index", 32'(hash_idx), 32'(ref_idx(VECS[v][47:0])));
        end

        // R3: neighbour bit in the same table byte must not admit the group
        wr_reg(5'h00, 8'h08);
        wr_reg(5'(8 + ai[5:3]), 8'(1) << (ai[2:0] ^ 3'd1));
        send_dest(ALLH);
        check("R3 wrong table bit rejects", 32'(accept), 32'd0);
        wr_reg(5'(8 + ai[5:3]), 8'(1) << ai[2:0]);
        send_dest(ALLH);
        check("R3 right table bit accepts", 32'(accept), 32'd1);

        // R7: extra bytes ignored, verdict held
        wr_reg(5'h00, 8'h00);
        send_dest(STA);
        check("R7 station accepted", 32'(accept), 32'd1);
        for (int i = 0; i < 3; i++) begin
            byte_vld = 1'b1; byte_data = 8'hA5;
            @(negedge clk);
        end
        byte_vld = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 verdict held", 32'(accept), 32'd1);
        check("R7 valid held", 32'(decision_vld), 32'd1);
        check("R7 hash held", 32'(hash_idx), 32'(ref_idx(STA)));

        // R9: start clears; same-cycle byte not taken
        frm_start = 1'b1; byte_vld = 1'b1; byte_data = 8'hEE;
        @(negedge clk);
        frm_start = 1'b0; byte_vld = 1'b0;
        check("R9 start clears verdict", 32'(decision_vld), 32'd0);
        for (int i = 0; i < 6; i++) begin
            byte_vld = 1'b1; byte_data = STA[47-8*i -: 8];
            @(negedge clk);
        end
        byte_vld = 1'b0;
        @(negedge clk);
        check("R9 byte with start ignored", 32'(accept), 32'd1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule